// File: doc/BRIEF.md
# JTAG Instruction Decoder and Data-Register Selector

This block sits next to an IEEE 1149.1 TAP state machine that lives elsewhere. The TAP reports its current state to this block as one-hot strobes. The block keeps a 4-bit instruction register. The loaded code decides which data register is placed between TDI and TDO. The block holds three data registers of its own: a 32-bit identification word, a single bypass cell and a single processor-reset cell. The boundary-scan cells sit outside the block. They are reached through a serial return pin and through gated capture, shift and update strobes. A mode output tells those cells to drive the package pins.

The processor-reset cell drives the system reset output combinationally from the shift stage. No update latch sits in that path. The cell has no effect on the TAP or on the instruction register. All registers are clocked by TCK. TDO is re-timed on the falling edge, and an enable output marks when TDO is valid.

Top module: `jtag_dr_select`

## Requirements
- R1: After trstN is low, or after a rising TCK edge with tlrState high, activeIr reads 4'h1 (identification). The reset cell reads 0 and bsExtest is low.
- R2: At Capture-IR the instruction shift stage loads 4'b0001. Each Shift-IR edge moves TDI into bit 3, and bit 0 is the next bit to leave on TDO.
- R3: activeIr changes only on a rising TCK edge with updateIr or tlrState high. Shifting alone leaves it unchanged.
- R4: Code 4'h1 selects the identification register. Capture-DR loads {version[3:0], part[15:0], maker[10:0], 1'b1}, and Shift-DR sends it out LSB first.
- R5: Code 4'hF selects the bypass cell. Capture-DR loads 0, and each bit from TDI appears on TDO one shift later.
- R6: Every code other than 4'h0, 4'h1, 4'h2 and 4'hC behaves exactly like 4'hF.
- R7: Code 4'hC selects the reset cell. Each Shift-DR edge copies TDI into it, and sysReset equals the cell at once, without waiting for Update-DR. Capture-DR leaves the cell unchanged. The cell keeps its value when another instruction is loaded, and a TAP reset clears it.
- R8: Code 4'h0 raises bsExtest from the Update-IR edge that loads it, and bsExtest stays high while the code is held. With this code, the boundary strobes follow the DR strobes and TDO carries bsTdo during Shift-DR.
- R9: Code 4'h2 also forwards the boundary strobes and routes bsTdo to TDO, but bsExtest stays low.
- R10: With any code other than 4'h0 and 4'h2, bsCapture, bsShift and bsUpdate stay low.
- R11: TDO and tdoEn change on the falling edge of TCK. tdoEn is high, and TDO carries the selected serial bit, only when the state at that edge is Shift-IR or Shift-DR. Otherwise TDO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tlrState | input | 1 | TAP is in Test-Logic-Reset |
| captureIr | input | 1 | TAP is in Capture-IR |
| shiftIr | input | 1 | TAP is in Shift-IR |
| updateIr | input | 1 | TAP is in Update-IR |
| captureDr | input | 1 | TAP is in Capture-DR |
| shiftDr | input | 1 | TAP is in Shift-DR |
| updateDr | input | 1 | TAP is in Update-DR |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| tdoEn | output | 1 | TDO valid (shift state) |
| activeIr | output | 4 | Instruction currently in force |
| bsTdo | input | 1 | Serial return from the boundary chain |
| bsCapture | output | 1 | Capture strobe to boundary cells |
| bsShift | output | 1 | Shift strobe to boundary cells |
| bsUpdate | output | 1 | Update strobe to boundary cells |
| bsExtest | output | 1 | Boundary cells take over the pins |
| sysReset | output | 1 | Processor reset from the reset cell |

## Verification
The hardest situation to reach is the reset cell keeping its value across instruction changes while it still responds to a TAP reset. The stimulus sets the cell through a DR scan under code 4'hC. It then runs a Capture-DR that must leave the cell untouched, and loads the identification code, with sysReset watched on every cycle. Afterwards it sets the cell again and ends with a Test-Logic-Reset cycle. Unlisted codes and the boundary-strobe gating are reached by complete IR loads followed by DR scans with distinct bit patterns.

// File: rtl/jtag_sel_pkg.sv
package jtag_sel_pkg;
  localparam int IR_W = 4;

  localparam logic [IR_W-1:0] INS_EXTEST  = 4'h0;
  localparam logic [IR_W-1:0] INS_IDCODE  = 4'h1;
  localparam logic [IR_W-1:0] INS_SAMPLE  = 4'h2;
  localparam logic [IR_W-1:0] INS_PRST    = 4'hC;
  localparam logic [IR_W-1:0] INS_BYPASS  = 4'hF;
  localparam logic [IR_W-1:0] IR_CAPTURE  = 4'b0001;

  typedef struct packed {
    logic tlr;
    logic capDr;
    logic shDr;
    logic shIr;
    logic selId;
    logic selByp;
    logic selRst;
    logic selBs;
  } dr_ctl_t;
endpackage

// File: rtl/jtag_sel_ctrl.sv
module jtag_sel_ctrl
  import jtag_sel_pkg::*;
(
  input  logic            tck,
  input  logic            trstN,
  input  logic            tlrState,
  input  logic            captureIr,
  input  logic            shiftIr,
  input  logic            updateIr,
  input  logic            captureDr,
  input  logic            shiftDr,
  input  logic            updateDr,
  input  logic            tdi,
  output logic [IR_W-1:0] activeIr,
  output logic            irSerial,
  output logic            bsCapture,
  output logic            bsShift,
  output logic            bsUpdate,
  output logic            bsExtest,
  output dr_ctl_t         ctl
);
  logic [IR_W-1:0] irShift;
  logic [IR_W-1:0] irReg;
  logic            isId, isRst, isBs;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift <= IR_CAPTURE;
      irReg   <= INS_IDCODE;
    end else if (tlrState) begin
      irReg   <= INS_IDCODE;
    end else begin
      if (captureIr)
        irShift <= IR_CAPTURE;
      else if (shiftIr)
        irShift <= {tdi, irShift[IR_W-1:1]};
      if (updateIr)
        irReg <= irShift;
    end
  end

  always_comb begin
    isId  = (irReg == INS_IDCODE);
    isRst = (irReg == INS_PRST);
    isBs  = (irReg == INS_EXTEST) || (irReg == INS_SAMPLE);
  end

  assign activeIr  = irReg;
  assign irSerial  = irShift[0];
  assign bsExtest  = (irReg == INS_EXTEST);
  assign bsCapture = captureDr & isBs;
  assign bsShift   = shiftDr & isBs;
  assign bsUpdate  = updateDr & isBs;

  always_comb begin
    ctl.tlr    = tlrState;
    ctl.capDr  = captureDr;
    ctl.shDr   = shiftDr;
    ctl.shIr   = shiftIr;
    ctl.selId  = isId;
    ctl.selRst = isRst;
    ctl.selBs  = isBs;
    ctl.selByp = !(isId || isRst || isBs);
  end

  // R1: a TAP reset cycle always leaves the identification code in force
  p_ir_reset_r1: assert property (@(posedge tck) disable iff (!trstN)
    tlrState |=> (activeIr == INS_IDCODE));

  // R3: no update, no reset -> instruction unchanged
  p_ir_hold_r3: assert property (@(posedge tck) disable iff (!trstN)
    (!updateIr && !tlrState) |=> $stable(activeIr));

  // R8: pin takeover can only begin at an Update-IR edge
  p_extest_upd_r8: assert property (@(posedge tck) disable iff (!trstN)
    $rose(bsExtest) |-> $past(updateIr));

  // R10: boundary strobes are only ever a gated copy of a DR strobe
  p_strobe_gate_r10: assert property (@(posedge tck) disable iff (!trstN)
    (bsCapture || bsShift || bsUpdate) |-> (captureDr || shiftDr || updateDr));
endmodule

// File: rtl/jtag_sel_dp.sv
module jtag_sel_dp
  import jtag_sel_pkg::*;
#(
  parameter int          ID_W    = 32,
  parameter logic [ID_W-1:0] ID_WORD = '1
) (
  input  logic    tck,
  input  logic    trstN,
  input  dr_ctl_t ctl,
  input  logic    tdi,
  input  logic    irSerial,
  input  logic    bsTdo,
  output logic    tdo,
  output logic    tdoEn,
  output logic    sysReset
);
  logic [ID_W-1:0] idShift;
  logic            bypCell;
  logic            rstCell;
  logic            drSerial;
  logic            serialNext;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      idShift <= ID_WORD;
      bypCell <= 1'b0;
      rstCell <= 1'b0;
    end else if (ctl.tlr) begin
      rstCell <= 1'b0;
    end else begin
      if (ctl.capDr && ctl.selId)
        idShift <= ID_WORD;
      else if (ctl.shDr && ctl.selId)
        idShift <= {tdi, idShift[ID_W-1:1]};
      if (ctl.capDr && ctl.selByp)
        bypCell <= 1'b0;
      else if (ctl.shDr && ctl.selByp)
        bypCell <= tdi;
      if (ctl.shDr && ctl.selRst)
        rstCell <= tdi;
    end
  end

  always_comb begin
    drSerial = bypCell;
    if (ctl.selId)       drSerial = idShift[0];
    else if (ctl.selRst) drSerial = rstCell;
    else if (ctl.selBs)  drSerial = bsTdo;
    serialNext = 1'b0;
    if (ctl.shIr)      serialNext = irSerial;
    else if (ctl.shDr) serialNext = drSerial;
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdo   <= serialNext;
      tdoEn <= ctl.shIr | ctl.shDr;
    end
  end

  assign sysReset = rstCell;

  // R7: the reset output follows the shifted bit on the very next edge
  p_rst_nolatch_r7: assert property (@(posedge tck) disable iff (!trstN)
    (ctl.shDr && ctl.selRst && !ctl.tlr) |=> (sysReset == $past(tdi)));

  // R5: bypass capture always yields zero
  p_bypass_cap_r5: assert property (@(posedge tck) disable iff (!trstN)
    (ctl.capDr && ctl.selByp && !ctl.tlr) |=> !bypCell);

  // R4: capture under identification loads the full word, LSB set
  p_id_cap_r4: assert property (@(posedge tck) disable iff (!trstN)
    (ctl.capDr && ctl.selId && !ctl.tlr) |=> idShift[0]);
endmodule

// File: rtl/jtag_dr_select.sv
module jtag_dr_select
  import jtag_sel_pkg::*;
#(
  parameter logic [3:0]  ID_VERSION = 4'h3,
  parameter logic [15:0] ID_PART    = 16'h9A5C,
  parameter logic [10:0] ID_MAKER   = 11'h01F
) (
  input  logic            tck,
  input  logic            trstN,
  input  logic            tlrState,
  input  logic            captureIr,
  input  logic            shiftIr,
  input  logic            updateIr,
  input  logic            captureDr,
  input  logic            shiftDr,
  input  logic            updateDr,
  input  logic            tdi,
  output logic            tdo,
  output logic            tdoEn,
  output logic [IR_W-1:0] activeIr,
  input  logic            bsTdo,
  output logic            bsCapture,
  output logic            bsShift,
  output logic            bsUpdate,
  output logic            bsExtest,
  output logic            sysReset
);
  localparam int ID_W = $bits(ID_VERSION) + $bits(ID_PART) + $bits(ID_MAKER) + 1;
  localparam logic [ID_W-1:0] ID_WORD = {ID_VERSION, ID_PART, ID_MAKER, 1'b1};

  dr_ctl_t ctl;
  logic    irSerial;

  jtag_sel_ctrl u_ctrl (
    .tck(tck), .trstN(trstN), .tlrState(tlrState),
    .captureIr(captureIr), .shiftIr(shiftIr), .updateIr(updateIr),
    .captureDr(captureDr), .shiftDr(shiftDr), .updateDr(updateDr),
    .tdi(tdi), .activeIr(activeIr), .irSerial(irSerial),
    .bsCapture(bsCapture), .bsShift(bsShift), .bsUpdate(bsUpdate),
    .bsExtest(bsExtest), .ctl(ctl)
  );

  jtag_sel_dp #(.ID_W(ID_W), .ID_WORD(ID_WORD)) u_dp (
    .tck(tck), .trstN(trstN), .ctl(ctl), .tdi(tdi),
    .irSerial(irSerial), .bsTdo(bsTdo),
    .tdo(tdo), .tdoEn(tdoEn), .sysReset(sysReset)
  );
endmodule

// File: tb/sim_jtag_dr_select.sv
module sim_jtag_dr_select;
  localparam logic [3:0]  VER  = 4'h3;
  localparam logic [15:0] PART = 16'h9A5C;
  localparam logic [10:0] MAKER = 11'h01F;
  localparam logic [31:0] IDW = {VER, PART, MAKER, 1'b1};
  localparam int TLR = 0, CIR = 1, SIR = 2, UIR = 3, CDR = 4, SDR = 5, UDR = 6;

  logic tck = 1'b0;
  logic trstN = 1'b0;
  logic [6:0] st = '0;
  logic tdi = 1'b0, bsTdo = 1'b0;
  logic tdo, tdoEn, bsCapture, bsShift, bsUpdate, bsExtest, sysReset;
  logic [3:0] activeIr;

  int errors = 0, checks = 0;
  int mIr = 1;
  bit mIq[$];
  bit mIdq[$];
  bit mByp = 0, mRst = 0;

  always #10 tck = ~tck;  // 50 MHz

  jtag_dr_select #(.ID_VERSION(VER), .ID_PART(PART), .ID_MAKER(MAKER)) u0 (
    .tck(tck), .trstN(trstN), .tlrState(st[TLR]),
    .captureIr(st[CIR]), .shiftIr(st[SIR]), .updateIr(st[UIR]),
    .captureDr(st[CDR]), .shiftDr(st[SDR]), .updateDr(st[UDR]),
    .tdi(tdi), .tdo(tdo), .tdoEn(tdoEn), .activeIr(activeIr),
    .bsTdo(bsTdo), .bsCapture(bsCapture), .bsShift(bsShift),
    .bsUpdate(bsUpdate), .bsExtest(bsExtest), .sysReset(sysReset)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int selOf(int ir);
    if (ir == 1) return 0;
    if (ir == 12) return 2;
    if (ir == 0 || ir == 2) return 3;
    return 1;
  endfunction

  // one TCK cycle; entered 2 ns after a rising edge
  task automatic step(logic [6:0] s, logic d, logic b, string tag);
    int sel;
    bit eTdo;
    sel = selOf(mIr);
    st = s; tdi = d; bsTdo = b;
    eTdo = 0;
    if (s[SIR]) eTdo = mIq[0];
    else if (s[SDR]) begin
      case (sel)
        0: eTdo = mIdq[0];
        1: eTdo = mByp;
        2: eTdo = mRst;
        default: eTdo = b;
      endcase
    end
    #17;
    chk(s[SIR] ? "R2" : tag, "tdo", tdo, eTdo);
    chk("R11", "tdoEn", tdoEn, s[SIR] | s[SDR]);
    chk("R3", "activeIr", activeIr, mIr);
    chk("R7", "sysReset", sysReset, mRst);
    chk("R8", "bsExtest", bsExtest, mIr == 0);
    chk("R10", "bsCapture", bsCapture, s[CDR] && sel == 3);
    chk("R10", "bsShift", bsShift, s[SDR] && sel == 3);
    chk("R10", "bsUpdate", bsUpdate, s[UDR] && sel == 3);
    @(posedge tck);
    if (s[TLR]) begin
      mIr = 1; mRst = 0;
    end else begin
      if (s[CIR]) mIq = '{1'b1, 1'b0, 1'b0, 1'b0};
      if (s[SIR]) begin void'(mIq.pop_front()); mIq.push_back(d); end
      if (s[UIR]) begin
        mIr = 0;
        foreach (mIq[i]) mIr |= int'(mIq[i]) << i;
      end
      if (s[CDR]) begin
        if (sel == 0) begin
          mIdq.delete();
          for (int i = 0; i < 32; i++) mIdq.push_back(IDW[i]);
        end else if (sel == 1) mByp = 0;
      end
      if (s[SDR]) begin
        if (sel == 0) begin void'(mIdq.pop_front()); mIdq.push_back(d); end
        else if (sel == 1) mByp = d;
        else if (sel == 2) mRst = d;
      end
    end
    #2;
  endtask

  task automatic loadIr(logic [3:0] code);
    step(7'(1 << CIR), 0, 0, "R2");
    for (int i = 0; i < 4; i++) step(7'(1 << SIR), code[i], 0, "R2");
    step('0, 0, 0, "R2");
    step(7'(1 << UIR), 0, 0, "R3");
    step('0, 0, 0, "R3");
  endtask

  task automatic scanDr(int n, logic [63:0] pat, string tag);
    step(7'(1 << CDR), 0, 0, tag);
    for (int i = 0; i < n; i++) step(7'(1 << SDR), pat[i], pat[i] ^ i[0], tag);
    step('0, 0, 0, tag);
    step(7'(1 << UDR), 0, 0, tag);
    step('0, 0, 0, tag);
  endtask

  initial begin
    repeat (20000) @(posedge tck);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    mIq = '{1'b1, 1'b0, 1'b0, 1'b0};
    for (int i = 0; i < 32; i++) mIdq.push_back(IDW[i]);
    @(posedge tck); #2;
    @(posedge tck); #17;
    chk("R1", "activeIr after trst", activeIr, 4'h1);
    chk("R1", "sysReset after trst", sysReset, 0);
    chk("R1", "bsExtest after trst", bsExtest, 0);
    chk("R11", "tdo after trst", tdo, 0);
    @(posedge tck); #2;
    trstN = 1'b1;
    step('0, 0, 0, "R1");
    scanDr(40, 64'h0000_00C3_F0F0_1234, "R4");
    loadIr(4'hF);
    scanDr(8, 64'hA5, "R5");
    loadIr(4'h7);
    scanDr(6, 64'h2D, "R6");
    loadIr(4'h3);
    scanDr(5, 64'h13, "R6");
    loadIr(4'hC);
    scanDr(1, 64'h1, "R7");
    chk("R7", "sysReset set", sysReset, 1);
    step(7'(1 << CDR), 0, 0, "R7");
    step('0, 0, 0, "R7");
    chk("R7", "capture keeps reset cell", sysReset, 1);
    loadIr(4'h1);
    chk("R7", "reset held across IR load", sysReset, 1);
    scanDr(4, 64'h6, "R4");
    loadIr(4'hC);
    scanDr(1, 64'h0, "R7");
    chk("R7", "sysReset released", sysReset, 0);
    scanDr(1, 64'h1, "R7");
    step(7'(1 << TLR), 0, 0, "R1");
    step('0, 0, 0, "R1");
    chk("R1", "TAP reset clears reset cell", sysReset, 0);
    loadIr(4'h0);
    chk("R8", "extest mode", bsExtest, 1);
    scanDr(10, 64'h2B6, "R8");
    loadIr(4'h2);
    chk("R9", "sample keeps pins", bsExtest, 0);
    scanDr(10, 64'h159, "R9");
    loadIr(4'h0);
    step(7'(1 << TLR), 0, 0, "R1");
    step('0, 0, 0, "R1");
    chk("R1", "TAP reset drops extest", bsExtest, 0);
    chk("R1", "TAP reset restores id code", activeIr, 4'h1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule